// File: doc/BRIEF.md
# Counter-Driven Periodic Bit-Pattern Generator

This block emits a fixed serial bit pattern over and over, one bit per clock. A modulo counter steps through the positions of the pattern, and a combinational lookup turns each counter value into the bit for that position. The serial output therefore depends only on the counter value and changes right after each rising clock edge.

Both the period and the pattern are parameters. Bit k of `PATTERN` is the bit emitted while the counter is at position k, so the least significant bit goes out first. Two configurations are the intended uses:

- a period of 8 with pattern bits 1,0,0,1,0,1,0,1;
- a period of 6 with pattern bits 1,0,0,1,0,1.

When the period is a power of two, the counter wraps by its natural binary overflow. Any other period uses an explicit compare-and-clear next-state function. Values at or above the period cannot be reached, and if one is ever entered it is sent back to position 0.

Top module: `seqgen_top`

## Requirements
- R1: While `rst_n` is low, the counter is held at position 0 (asynchronous clear), and `ser_o` shows bit 0 of `PATTERN`. That bit is 1 for both intended configurations.
- R2: Each rising clock edge with `rst_n` high advances the output by exactly one pattern position.
- R3: After position `PERIOD`-1, the next clock returns the output to position 0. A counter value of `PERIOD` or more also returns to position 0 on the next clock.
- R4: `ser_o` equals `PATTERN[k]` while the counter is at position k. Bit k of the parameter maps to position k, with the LSB sent first.
- R5: With `PERIOD`=8 and `PATTERN`=8'b1010_1001, `ser_o` repeats 1,0,0,1,0,1,0,1.
- R6: With `PERIOD`=6 and `PATTERN`=6'b10_1001, `ser_o` repeats 1,0,0,1,0,1.
- R7: Asserting `rst_n` in the middle of a period restarts the pattern. The first bit after release is position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset to position 0 |
| ser_o | output | 1 | Serial pattern bit for the current position |

## Verification
The bench drives both configurations side by side for three full periods after reset and compares every output bit against queues of expected bits. Because 8 and 6 are not multiples of each other, a wrong wrap point, a skipped position, or a bit-order reversal gives a mismatch in at least one of the two streams. A reset pulse placed partway through a period separates a true restart from a design that merely keeps counting.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    localparam int MOD8_PERIOD = 8;
    localparam logic [MOD8_PERIOD-1:0] MOD8_PATTERN = 8'b1010_1001;

    localparam int MOD6_PERIOD = 6;
    localparam logic [MOD6_PERIOD-1:0] MOD6_PATTERN = 6'b10_1001;

    function automatic int cnt_width(input int period);
        return (period > 2) ? $clog2(period) : 1;
    endfunction

    function automatic bit is_pow2(input int period);
        return (period > 0) && ((period & (period - 1)) == 0);
    endfunction

endpackage

// File: rtl/seqgen_modcnt.sv
module seqgen_modcnt #(
    parameter int PERIOD = 8,
    localparam int CW = seqgen_pkg::cnt_width(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] state_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CW-1:0] inc_w;

    assign inc_w = st_q.cnt + 1'b1;

    generate
        if (seqgen_pkg::is_pow2(PERIOD)) begin : g_natural_wrap
            always_comb begin
                st_d = st_q;
                st_d.cnt = inc_w;
            end
        end else begin : g_compare_wrap
            always_comb begin
                st_d = st_q;
                if (st_q.cnt >= LAST) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = inc_w;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.cnt;

    // R2: one step per clock below the last position
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o < LAST) |=> (state_o == CW'($past(state_o) + 1'b1)));

    // R3: last position returns to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == LAST) |=> (state_o == '0));

    // R3: the counter never leaves the legal range
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(state_o) < PERIOD));

endmodule

// File: rtl/seqgen_lut.sv
module seqgen_lut #(
    parameter int PERIOD = 8,
    parameter logic [PERIOD-1:0] PATTERN = seqgen_pkg::MOD8_PATTERN,
    localparam int CW = seqgen_pkg::cnt_width(PERIOD)
) (
    input  logic [CW-1:0] state_i,
    output logic          bit_o
);

    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < PERIOD; k++) begin
            if (state_i == CW'(k)) begin
                bit_o = PATTERN[k];
            end
        end
    end

endmodule

// File: rtl/seqgen_top.sv
module seqgen_top #(
    parameter int PERIOD = seqgen_pkg::MOD8_PERIOD,
    parameter logic [PERIOD-1:0] PATTERN = seqgen_pkg::MOD8_PATTERN
) (
    input  logic clk,
    input  logic rst_n,
    output logic ser_o
);

    localparam int CW = seqgen_pkg::cnt_width(PERIOD);

    logic [CW-1:0] state_w;

    seqgen_modcnt #(.PERIOD(PERIOD)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (state_w)
    );

    seqgen_lut #(.PERIOD(PERIOD), .PATTERN(PATTERN)) lut_i (
        .state_i (state_w),
        .bit_o   (ser_o)
    );

    // R1/R4: position zero always presents the leading pattern bit
    p_lead_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == '0) |-> (ser_o == PATTERN[0]));

endmodule

// File: tb/seqgen_top_tb_top.sv
`timescale 1ns/1ps
module seqgen_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser8, ser6;
    int checks = 0;
    int errors = 0;
    bit ref8[$] = '{1, 0, 0, 1, 0, 1, 0, 1};
    bit ref6[$] = '{1, 0, 0, 1, 0, 1};

    always #2 clk = ~clk;

    seqgen_top dut_i (.clk(clk), .rst_n(rst_n), .ser_o(ser8));

    seqgen_top #(
        .PERIOD(seqgen_pkg::MOD6_PERIOD),
        .PATTERN(seqgen_pkg::MOD6_PATTERN)
    ) dut6_i (.clk(clk), .rst_n(rst_n), .ser_o(ser6));

    task automatic check(input string req, input logic act, input logic exp, input int cyc);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // Samples both streams for n cycles; the caller stands at a falling edge.
    task automatic run_stream(input int n, input string first_tag);
        for (int c = 0; c < n; c++) begin
            string t8, t6;
            t8 = (c == 0) ? first_tag : ((c % 8 == 0) ? "R3" : "R2/R4/R5");
            t6 = (c == 0) ? first_tag : ((c % 6 == 0) ? "R3" : "R2/R4/R6");
            check(t8, ser8, ref8[c % 8], c);
            check(t6, ser6, ref6[c % 6], c);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", ser8, 1'b1, -1);
        check("R1", ser6, 1'b1, -1);
        rst_n = 1'b1;
        run_stream(24, "R1");
        // mid-period reset: position 5 of both streams
        run_stream(5, "R7");
        rst_n = 1'b0;
        #1;
        check("R7", ser8, 1'b1, -1);
        check("R7", ser6, 1'b1, -1);
        repeat (2) @(negedge clk);
        check("R1", ser8, 1'b1, -1);
        check("R1", ser6, 1'b1, -1);
        rst_n = 1'b1;
        run_stream(24, "R7");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule